// File: doc/BRIEF.md
# Fractional-Ratio Memory Clock Generator

This block derives a slower memory-side clock from the core clock. A 3-bit ratio code selects a divide ratio from 2 to 5 in steps of one half. A separate start control decides when a new code is applied. Integer ratios give a period of fixed length. A half-integer ratio N+0.5 alternates periods of N and N+1 core cycles, so the average period is exact. In every period the clock is high for the integer part of half the period length and low for the rest.

Besides the clock level, the block gives a one-core-cycle pulse at each memory-clock rising edge. Downstream logic in the core domain uses this pulse as a clock enable. A mask input forces the clock output low but leaves the pulses running. A new ratio is never applied in the middle of a period, so no shortened pulse reaches the memory.

Top module: `memclk_gen`

## Requirements
- R1: Ratio code c (1 to 7) selects a divide ratio of (c+3)/2 core cycles: 1→2, 2→2.5, 3→3, 4→3.5, 5→4, 6→4.5, 7→5. Any two consecutive periods together last c+3 cycles.
- R2: After reset, and for as long as start has not yet gone from 0 to 1, `mclk_out` and `mclk_rise` stay 0. Reset also returns the active ratio to code 3 (divide by 3).
- R3: A change on `ratio_code` has no effect unless `start` goes from 0 to 1 (sampled 0 and then 1 on consecutive clock edges). Holding `start` at 1 or taking it back to 0 does not reload the code.
- R4: If `ratio_code` is 000 when `start` rises, the ratio in use stays unchanged.
- R5: For a half-integer ratio N+0.5, the period lengths alternate between N and N+1 core cycles. The first period after a switch has N cycles.
- R6: In every period of P core cycles, `mclk_out` is high for exactly floor(P/2) cycles, starting at the rising edge.
- R7: A new ratio starts only at a period boundary. While a switch is in progress, every period has the length of the old ratio or of the new one, with no shortened period.
- R8: While `mask` is 1, `mclk_out` stays 0 while `mclk_rise` keeps pulsing. When `mask` returns to 0, the clock resumes with the same timing.
- R9: `mclk_rise` lasts one core cycle per period. While the clock is unmasked, it is high in the same cycle in which `mclk_out` goes high.
- R10: If the first start after reset arrives with code 000, the generator runs at divide by 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_code | input | 3 | Requested divide ratio code |
| start | input | 1 | Start control; a 0-to-1 change applies the code |
| mask | input | 1 | 1 holds the clock output low |
| mclk_out | output | 1 | Divided memory clock |
| mclk_rise | output | 1 | One-cycle pulse at each memory-clock rising edge |

## Verification
The hardest case to reach is a ratio switch that lands while the clock is running: the pending code must wait for the end of the current period, and only the period lengths and high phases at the ports show whether that happened. The stimulus steps through every code with a fresh 0-to-1 start while the generator is already running. A monitor measures every period and its high phase, so any shortened or malformed period during a switch is caught. Other directed steps hold start high or pull it low while the code changes, rise start with code 000, and mask the clock in the middle of a run.

// File: rtl/memclk_pkg.sv
package memclk_pkg;
  localparam int CODE_W   = 3;
  localparam int HALF_W   = 4;
  localparam int HALF_OFS = 3;
  localparam logic [CODE_W-1:0] RESET_CODE = 3'b011;

  // Ratio expressed in half core cycles: code + 3.
  function automatic logic [HALF_W-1:0] half_ratio(input logic [CODE_W-1:0] code);
    return HALF_W'(code) + HALF_W'(HALF_OFS);
  endfunction
endpackage

// File: rtl/memclk_ctrl.sv
module memclk_ctrl
  import memclk_pkg::*;
#(
  parameter int C_W = CODE_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [C_W-1:0] ratio_code,
  input  logic           start,
  input  logic           boundary,
  output logic           running,
  output logic           launch,
  output logic           apply,
  output logic [C_W-1:0] act_code
);
  logic           start_q;
  logic           start_rise;
  logic           code_ok;
  logic [C_W-1:0] pend_code;
  logic           pend_valid;

  assign start_rise = start & ~start_q;
  assign code_ok    = (ratio_code != '0);
  assign launch     = start_rise & ~running;
  assign apply      = pend_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q    <= 1'b0;
      running    <= 1'b0;
      act_code   <= C_W'(RESET_CODE);
      pend_code  <= '0;
      pend_valid <= 1'b0;
    end else begin
      start_q <= start;
      if (launch) begin
        running    <= 1'b1;
        pend_valid <= 1'b0;
        if (code_ok) act_code <= ratio_code;
      end else begin
        if (running && boundary && pend_valid) begin
          act_code   <= pend_code;
          pend_valid <= 1'b0;
        end
        if (running && start_rise && code_ok) begin
          pend_code  <= ratio_code;
          pend_valid <= 1'b1;
        end
      end
    end
  end

  AST_CODE_NONZERO: assert property (@(posedge clk) disable iff (rst)
    running |-> (act_code != '0));  // R4
  AST_SWITCH_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (running && !boundary) |=> $stable(act_code));  // R7
  AST_STAY_RUNNING: assert property (@(posedge clk) disable iff (rst)
    running |=> running);  // R3
endmodule

// File: rtl/memclk_counter.sv
module memclk_counter
  import memclk_pkg::*;
#(
  parameter int C_W = CODE_W,
  parameter int H_W = HALF_W,
  parameter int CNT_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           running,
  input  logic           launch,
  input  logic           apply,
  input  logic [C_W-1:0] act_code,
  output logic           boundary,
  output logic           level,
  output logic           first
);
  logic [H_W-1:0]   half;
  logic [CNT_W-1:0] base_len;
  logic [CNT_W-1:0] per_len;
  logic [CNT_W-1:0] hi_len;
  logic [CNT_W-1:0] cnt;
  logic             alt;

  assign half     = half_ratio(act_code);
  assign base_len = CNT_W'(half >> 1);
  assign per_len  = base_len + CNT_W'(half[0] & alt);
  assign hi_len   = per_len >> 1;
  assign boundary = running && (cnt == per_len - CNT_W'(1));
  assign level    = (cnt < hi_len);
  assign first    = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      alt <= 1'b0;
    end else if (launch) begin
      cnt <= '0;
      alt <= 1'b0;
    end else if (running) begin
      if (boundary) begin
        cnt <= '0;
        alt <= apply ? 1'b0 : ~alt;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    running |-> (cnt < per_len));  // R7
  AST_BOUNDARY_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (boundary && !launch) |=> (cnt == '0));  // R1
endmodule

// File: rtl/memclk_out.sv
module memclk_out (
  input  logic clk,
  input  logic rst,
  input  logic running,
  input  logic mask,
  input  logic level,
  input  logic first,
  output logic mclk_out,
  output logic mclk_rise
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mclk_out  <= 1'b0;
      mclk_rise <= 1'b0;
    end else begin
      mclk_out  <= running & ~mask & level;
      mclk_rise <= running & first;
    end
  end

  AST_MASK_HOLDS_LOW: assert property (@(posedge clk) disable iff (rst)
    mask |=> !mclk_out);  // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !running |=> (!mclk_out && !mclk_rise));  // R2
  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mclk_rise |=> !mclk_rise);  // R9
  AST_RISE_WITH_CLOCK: assert property (@(posedge clk) disable iff (rst)
    (mclk_rise && !mclk_out) |-> $past(mask));  // R9
endmodule

// File: rtl/memclk_gen.sv
module memclk_gen
  import memclk_pkg::*;
#(
  parameter int C_W   = CODE_W,
  parameter int CNT_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [C_W-1:0] ratio_code,
  input  logic           start,
  input  logic           mask,
  output logic           mclk_out,
  output logic           mclk_rise
);
  logic           running;
  logic           launch;
  logic           apply;
  logic           boundary;
  logic           level;
  logic           first;
  logic [C_W-1:0] act_code;

  memclk_ctrl #(.C_W(C_W)) u_ctrl (
    .clk(clk), .rst(rst), .ratio_code(ratio_code), .start(start),
    .boundary(boundary), .running(running), .launch(launch),
    .apply(apply), .act_code(act_code)
  );

  memclk_counter #(.C_W(C_W), .H_W(HALF_W), .CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst(rst), .running(running), .launch(launch),
    .apply(apply), .act_code(act_code), .boundary(boundary),
    .level(level), .first(first)
  );

  memclk_out u_out (
    .clk(clk), .rst(rst), .running(running), .mask(mask),
    .level(level), .first(first), .mclk_out(mclk_out), .mclk_rise(mclk_rise)
  );
endmodule

// File: tb/memclk_gen_bench.sv
module memclk_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] ratio_code = 3'b000;
  logic       start = 1'b0;
  logic       mask = 1'b0;
  logic       mclk_out;
  logic       mclk_rise;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // monitor state
  int  rise_n = 0;
  int  run_len = 0;
  int  run_hi = 0;
  int  p_last = 0, p_prev = 0, h_last = 0;
  bit  have_first = 1'b0;
  bit  mon_on = 1'b1;
  bit  prev_rise = 1'b0;

  // {code, two-period sum, shorter period}
  localparam logic [11:0] VEC [7] = '{
    {3'd1, 5'd4,  4'd2}, {3'd2, 5'd5, 4'd2}, {3'd3, 5'd6,  4'd3},
    {3'd4, 5'd7,  4'd3}, {3'd5, 5'd8, 4'd4}, {3'd6, 5'd9,  4'd4},
    {3'd7, 5'd10, 4'd5}};

  memclk_gen u_memclk_gen (
    .clk(clk), .rst(rst), .ratio_code(ratio_code), .start(start),
    .mask(mask), .mclk_out(mclk_out), .mclk_rise(mclk_rise)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Period monitor, sampled away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (rst) begin
        rise_n = 0; run_len = 0; run_hi = 0; have_first = 1'b0;
        p_last = 0; p_prev = 0; prev_rise = 1'b0;
      end else begin
        if (mclk_rise && prev_rise)
          check(1'b0, "R9 pulse width", 2, 1);
        if (mclk_rise && mon_on)
          check(mclk_out == 1'b1, "R9 rise with clock", int'(mclk_out), 1);
        if (mclk_rise) begin
          if (have_first) begin
            p_prev = p_last;
            p_last = run_len;
            h_last = run_hi;
            if (mon_on) begin
              check(run_len >= 2 && run_len <= 5, "R7 period length", run_len, 2);
              check(run_hi == run_len / 2, "R6 high phase", run_hi, run_len / 2);
            end
          end
          have_first = 1'b1;
          rise_n++;
          run_len = 1;
          run_hi = mclk_out ? 1 : 0;
        end else begin
          run_len++;
          if (mclk_out) run_hi++;
        end
        prev_rise = mclk_rise;
      end
    end
  end

  task automatic wait_rises(input int n);
    int target;
    target = rise_n + n;
    while (rise_n < target) @(negedge clk);
  endtask

  task automatic pulse_start(input logic [2:0] code);
    @(negedge clk);
    ratio_code = code;
    start = 1'b0;
    repeat (2) @(negedge clk);
    start = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    while (cycles < 100000) @(negedge clk);
    check(1'b0, "watchdog", cycles, 0);
    finish_run();
  end

  initial begin
    int hi_seen;
    int rises_before;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R2: idle before first start
    ratio_code = 3'd5;
    hi_seen = 0;
    repeat (40) begin
      @(negedge clk);
      if (mclk_out || mclk_rise) hi_seen++;
    end
    check(hi_seen == 0, "R2 idle before start", hi_seen, 0);

    // R10: first start with code 000 runs at divide by 3
    pulse_start(3'b000);
    wait_rises(4);
    check(p_last == 3 && p_prev == 3, "R10 default ratio", p_last, 3);

    // R1 / R5 vector walk
    for (int i = 0; i < 7; i++) begin
      pulse_start(VEC[i][11:9]);
      wait_rises(5);
      check(p_last + p_prev == int'(VEC[i][8:4]), "R1 two-period sum",
            p_last + p_prev, int'(VEC[i][8:4]));
      check((p_last < p_prev ? p_last : p_prev) == int'(VEC[i][3:0]),
            "R5 short period", (p_last < p_prev ? p_last : p_prev), int'(VEC[i][3:0]));
    end

    // R3: code change while start stays 1, then start falls
    ratio_code = 3'd1;
    wait_rises(6);
    check(p_last + p_prev == 10, "R3 code ignored with start high", p_last + p_prev, 10);
    start = 1'b0;
    wait_rises(6);
    check(p_last + p_prev == 10, "R3 code ignored on start fall", p_last + p_prev, 10);

    // R4: start rise with code 000 keeps divide by 5
    pulse_start(3'b000);
    wait_rises(6);
    check(p_last == 5 && p_prev == 5, "R4 reserved code kept ratio", p_last, 5);

    // R7: switch from 5 to 2, every period must be 5 or 2
    pulse_start(3'd1);
    for (int k = 0; k < 6; k++) begin
      wait_rises(1);
      if (k > 0)
        check(p_last == 5 || p_last == 2, "R7 switch period", p_last, 2);
    end
    check(p_last == 2, "R7 new ratio in use", p_last, 2);

    // R8: mask holds output low, pulses continue
    pulse_start(3'd3);
    wait_rises(4);
    mon_on = 1'b0;
    @(negedge clk);
    mask = 1'b1;
    @(negedge clk);
    rises_before = rise_n;
    hi_seen = 0;
    repeat (30) begin
      @(negedge clk);
      if (mclk_out) hi_seen++;
    end
    check(hi_seen == 0, "R8 masked output low", hi_seen, 0);
    check(rise_n - rises_before == 10, "R8 pulses continue", rise_n - rises_before, 10);
    mask = 1'b0;
    wait_rises(3);
    mon_on = 1'b1;
    wait_rises(2);
    check(p_last == 3 && h_last == 1, "R8 resumes after unmask", h_last, 1);

    // R2: reset mid-run clears output and returns to divide by 3
    @(negedge clk);
    rst = 1'b1;
    start = 1'b0;
    repeat (2) @(negedge clk);
    check(mclk_out == 1'b0 && mclk_rise == 1'b0, "R2 reset state", int'(mclk_out), 0);
    rst = 1'b0;
    hi_seen = 0;
    repeat (12) begin
      @(negedge clk);
      if (mclk_out || mclk_rise) hi_seen++;
    end
    check(hi_seen == 0, "R2 idle after reset", hi_seen, 0);
    pulse_start(3'b000);
    wait_rises(4);
    check(p_last == 3 && p_prev == 3, "R2 reset restores divide by 3", p_last, 3);

    finish_run();
  end
endmodule